// File: doc/BRIEF.md
# Converter-Side Serial Result Shifter

This block stands in for the digital output port of a 10-bit sampling converter so that host serial controllers can be tested against it. It runs on a fast system clock and samples the host's active-low chip select and serial clock as ordinary synchronous inputs. A falling chip select begins a conversion. It captures the parallel result and sub-bit inputs at that moment, enables the data line and holds it low while the conversion runs. The conversion time is counted in serial-clock rising edges.

After the conversion edges, each serial-clock rising edge presents the next bit. The result goes out MSB first, then the two sub-bits, and then zeros for as long as the host keeps clocking with chip select low. With the default conversion time of three edges, a 16-clock transfer carries 3 zeros, 10 data bits, 2 sub-bits and 1 trailing zero. A host that samples on the falling edge and uses 13 clocks sees 2 zeros ahead of the MSB.

Raising chip select during the conversion aborts it and starts a long acquisition lockout. Raising it later ends the frame and starts a shorter recovery lockout. A start that arrives during either lockout raises a one-cycle timing-violation flag, and that low period is ignored.

Top module: `serial_result_shifter`

## Requirements
- R1: A chip-select fall accepted outside any lockout sets `dout_oe` high with `dout` low on the following clock and clears `timing_err`.
- R2: The bit position advances by exactly one per rising edge of `sclk`, however long `sclk` stays high. `dout` changes only after an `sclk` rise or a chip-select edge.
- R3: Bit positions 0 to CONV_EDGES-1 (0 to 2 by default) output 0. Position 0 is the position right after the fall, and position p is the position after the p-th `sclk` rise.
- R4: Positions CONV_EDGES to CONV_EDGES+9 output `result` from bit 9 down to bit 0. The next two positions output `sub_bits[1]` and then `sub_bits[0]`.
- R5: Every position from CONV_EDGES+12 (15 by default) onward outputs 0, up to any number of clocks.
- R6: While chip select is sampled high, `dout_oe` and `dout` are both 0 on the next clock.
- R7: After a frame ends at position CONV_EDGES or later, a fall seen REC_CYC or fewer clock edges after the edge that saw the rise is rejected. A fall seen REC_CYC+1 or more edges later is accepted. A rejected start pulses `timing_err` and keeps `dout_oe` at 0 for that whole low period, whatever `sclk` does.
- R8: A rise of chip select at a position below CONV_EDGES aborts the conversion and imposes the same rule with ACQ_CYC (default 12, greater than REC_CYC) in place of REC_CYC.
- R9: Changes on `result` and `sub_bits` after the accepted fall do not change the bits of that frame.
- R10: `timing_err` is high for exactly one clock, and only on the clock after a chip-select fall.
- R11: After reset, `dout`, `dout_oe` and `timing_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| result | input | DATA_W | Conversion value captured at the chip-select fall |
| sub_bits | input | SUB_W | Sub-bits captured at the chip-select fall |
| dout | output | 1 | Serial data line value |
| dout_oe | output | 1 | Output enable of the data line (low means high impedance) |
| timing_err | output | 1 | One-cycle pulse for a start that violates a lockout |

## Verification
The checker verifies the cycle-level framing rules on every clock. These are the response to a chip-select fall, which is either an enable or a violation pulse, the quiet outputs while chip select is high, the data line holding between serial edges, and the one-cycle violation pulse. Only the bench scenarios can show the bit order of the frame, including the leading zeros, the MSB-first data, the sub-bits and the endless zero tail. The same holds for capturing the inputs at the fall and for the exact lockout lengths that separate an abort from a completed frame at both boundaries.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CONV   = 2'd1,
        PH_SHIFT  = 2'd2,
        PH_REJECT = 2'd3
    } srs_phase_e;

endpackage

// File: rtl/srs_edge.sv
module srs_edge #(
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = din;
        rise   = din & ~prev_q;
        fall   = ~din & prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_LVL;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/srs_gap_timer.sv
module srs_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
        busy = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/serial_result_shifter.sv
module serial_result_shifter
    import srs_pkg::*;
#(
    parameter int DATA_W     = 10,
    parameter int SUB_W      = 2,
    parameter int CONV_EDGES = 3,
    parameter int ACQ_CYC    = 12,
    parameter int REC_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] result,
    input  logic [SUB_W-1:0]  sub_bits,
    output logic              dout,
    output logic              dout_oe,
    output logic              timing_err
);
    localparam int WORD_W   = DATA_W + SUB_W;
    localparam int TAIL_POS = CONV_EDGES + WORD_W;
    localparam int POS_W    = $clog2(TAIL_POS + 1);
    localparam int GAP_MAX  = (ACQ_CYC > REC_CYC) ? ACQ_CYC : REC_CYC;
    localparam int GAP_W    = $clog2(GAP_MAX + 1);

    localparam logic [POS_W-1:0] CONV_P = POS_W'(CONV_EDGES);
    localparam logic [POS_W-1:0] TAIL_P = POS_W'(TAIL_POS);
    localparam logic [GAP_W-1:0] ACQ_V  = GAP_W'(ACQ_CYC);
    localparam logic [GAP_W-1:0] REC_V  = GAP_W'(REC_CYC);

    typedef struct packed {
        srs_phase_e        phase;
        logic [POS_W-1:0]  pos;
        logic [WORD_W-1:0] word;
        logic              dout;
        logic              oe;
        logic              err;
    } core_t;

    core_t d, q;

    logic             cs_rise, cs_fall, sclk_rise, sclk_fall_unused;
    logic             gap_load, gap_busy;
    logic [GAP_W-1:0] gap_val;
    logic [POS_W-1:0] pos_nxt;

    // chip select idles high, so its detector resets high
    srs_edge #(.IDLE_LVL(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .din(cs_n),
        .rise(cs_rise), .fall(cs_fall)
    );

    srs_edge #(.IDLE_LVL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .din(sclk),
        .rise(sclk_rise), .fall(sclk_fall_unused)
    );

    srs_gap_timer #(.W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load),
        .load_val(gap_val), .busy(gap_busy)
    );

    // bit value presented at a given frame position
    function automatic logic bit_at(input logic [WORD_W-1:0] w,
                                    input logic [POS_W-1:0]  p);
        logic [WORD_W-1:0] sh;
        if (p < CONV_P)       return 1'b0;
        else if (p < TAIL_P) begin
            sh = w << (p - CONV_P);
            return sh[WORD_W-1];
        end
        else                  return 1'b0;
    endfunction

    assign pos_nxt = (q.pos == TAIL_P) ? q.pos : q.pos + 1'b1;

    always_comb begin
        d        = q;
        d.err    = 1'b0;
        gap_load = 1'b0;
        gap_val  = ACQ_V;
        unique case (q.phase)
            PH_IDLE: begin
                if (cs_fall) begin
                    if (gap_busy) begin
                        d.phase = PH_REJECT;
                        d.err   = 1'b1;
                    end else begin
                        d.phase = (CONV_EDGES == 0) ? PH_SHIFT : PH_CONV;
                        d.pos   = '0;
                        d.word  = {result, sub_bits};
                        d.oe    = 1'b1;
                        d.dout  = bit_at({result, sub_bits}, '0);
                    end
                end
            end
            PH_CONV, PH_SHIFT: begin
                if (cs_rise) begin
                    d.phase  = PH_IDLE;
                    d.oe     = 1'b0;
                    d.dout   = 1'b0;
                    gap_load = 1'b1;
                    gap_val  = (q.phase == PH_CONV) ? ACQ_V : REC_V;
                end else if (sclk_rise) begin
                    d.pos   = pos_nxt;
                    d.dout  = bit_at(q.word, pos_nxt);
                    d.phase = (pos_nxt < CONV_P) ? PH_CONV : PH_SHIFT;
                end
            end
            PH_REJECT: begin
                if (cs_rise) d.phase = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout       = q.dout;
    assign dout_oe    = q.oe;
    assign timing_err = q.err;
endmodule

// File: rtl/srs_checker.sv
module srs_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic dout,
    input logic dout_oe,
    input logic timing_err
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R1, R7, R8: a fall yields either an enabled low line or a violation pulse
    a_r1_start_response: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $fell(cs_n) |=> ((dout_oe != timing_err) && !dout));

    // R6: chip select high silences the line on the next clock
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        cs_n |=> (!dout_oe && !dout));

    // R6: data is low whenever the output is disabled
    a_r6_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

    // R2: data holds between serial edges and chip-select edges
    a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (!$rose(sclk) && $stable(cs_n)) |=> $stable(dout));

    // R10: a violation pulse needs a fall on the previous edge
    a_r10_err_source: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$fell(cs_n) |=> !timing_err);

    // R10: the violation pulse lasts one clock
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |=> !timing_err);
endmodule

bind serial_result_shifter srs_checker u_srs_checker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .dout(dout), .dout_oe(dout_oe), .timing_err(timing_err)
);

// File: tb/tb_serial_result_shifter.sv
`timescale 1ns/1ps
module tb_serial_result_shifter;
    localparam int DATA_W = 10;
    localparam int SUB_W  = 2;
    localparam int CONV   = 3;
    localparam int ACQ    = 12;
    localparam int REC    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              sclk = 1'b0;
    logic [DATA_W-1:0] result = '0;
    logic [SUB_W-1:0]  sub_bits = '0;
    logic              dout, dout_oe, timing_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    serial_result_shifter #(
        .DATA_W(DATA_W), .SUB_W(SUB_W), .CONV_EDGES(CONV),
        .ACQ_CYC(ACQ), .REC_CYC(REC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .result(result), .sub_bits(sub_bits),
        .dout(dout), .dout_oe(dout_oe), .timing_err(timing_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_bit(input logic [DATA_W-1:0] v,
                                   input logic [SUB_W-1:0] s, input int p);
        if (p < CONV)               return 0;
        else if (p < CONV + DATA_W) return int'(v[DATA_W-1-(p-CONV)]);
        else if (p < CONV + DATA_W + SUB_W) return int'(s[SUB_W-1-(p-CONV-DATA_W)]);
        else                        return 0;
    endfunction

    task automatic pulse();
        @(negedge clk) sclk = 1'b1;
        @(negedge clk) sclk = 1'b0;
        @(negedge clk);
    endtask

    // raise chip select, wait m edges, then lower it; fall is seen m edges after the rise
    task automatic start_after(input int m);
        @(negedge clk) cs_n = 1'b1;
        repeat (m) @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_frame();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 dout after reset", dout, 0);
        chk("R11 oe after reset", dout_oe, 0);
        chk("R11 err after reset", timing_err, 0);
    endtask

    task automatic t_frame(input logic [DATA_W-1:0] v, input logic [SUB_W-1:0] s,
                           input int nclk);
        result = v; sub_bits = s;
        start_after(ACQ + 2);
        chk("R1 oe on start", dout_oe, 1);
        chk("R1 dout low on start", dout, 0);
        chk("R1 no err on start", timing_err, 0);
        for (int p = 1; p <= nclk; p++) begin
            pulse();
            if (p < CONV)               chk("R3 leading zero", dout, exp_bit(v, s, p));
            else if (p < CONV + DATA_W + SUB_W) chk("R4 data or sub bit", dout, exp_bit(v, s, p));
            else                        chk("R5 zero tail", dout, 0);
            chk("R10 no err mid frame", timing_err, 0);
        end
        end_frame();
        chk("R6 oe off after frame", dout_oe, 0);
        chk("R6 dout low after frame", dout, 0);
    endtask

    task automatic t_hold();
        logic [DATA_W-1:0] v = 10'h2C9;
        logic [SUB_W-1:0]  s = 2'b01;
        result = v; sub_bits = s;
        start_after(ACQ + 2);
        repeat (4) pulse();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R2 hold with sclk low", dout, exp_bit(v, s, 4));
        end
        @(negedge clk) sclk = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 single step for long high", dout, exp_bit(v, s, 5));
        sclk = 1'b0;
        pulse();
        chk("R2 next position", dout, exp_bit(v, s, 6));
        end_frame();
    endtask

    task automatic t_capture();
        logic [DATA_W-1:0] v = 10'h1A6;
        logic [SUB_W-1:0]  s = 2'b10;
        result = v; sub_bits = s;
        start_after(ACQ + 2);
        result = ~v; sub_bits = ~s;
        for (int p = 1; p <= 16; p++) begin
            pulse();
            chk("R9 captured value kept", dout, exp_bit(v, s, p));
        end
        end_frame();
    endtask

    task automatic t_recovery();
        result = 10'h3C3; sub_bits = 2'b11;
        start_after(ACQ + 2);
        repeat (16) pulse();
        start_after(1);
        chk("R7 err early after frame", timing_err, 1);
        chk("R7 oe stays off", dout_oe, 0);
        @(negedge clk);
        chk("R10 err one cycle", timing_err, 0);
        repeat (3) pulse();
        chk("R7 ignored frame oe", dout_oe, 0);
        chk("R7 ignored frame dout", dout, 0);
        end_frame();
        start_after(ACQ + 2);
        repeat (14) pulse();
        start_after(REC);
        chk("R7 boundary reject", timing_err, 1);
        end_frame();
        start_after(ACQ + 2);
        repeat (16) pulse();
        start_after(REC + 1);
        chk("R7 boundary accept err", timing_err, 0);
        chk("R7 boundary accept oe", dout_oe, 1);
        end_frame();
    endtask

    task automatic t_abort();
        result = 10'h0F0; sub_bits = 2'b01;
        start_after(ACQ + 2);
        repeat (2) pulse();
        start_after(ACQ);
        chk("R8 abort boundary reject", timing_err, 1);
        chk("R8 abort reject oe", dout_oe, 0);
        end_frame();
        start_after(ACQ + 2);
        start_after(REC + 1);
        chk("R8 abort longer than recovery", timing_err, 1);
        end_frame();
        start_after(ACQ + 2);
        pulse();
        start_after(ACQ + 1);
        chk("R8 abort boundary accept err", timing_err, 0);
        chk("R8 abort boundary accept oe", dout_oe, 1);
        chk("R8 abort accept dout", dout, 0);
        end_frame();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(10'h2B5, 2'b10, 20);
        t_frame(10'h3FF, 2'b11, 16);
        t_frame(10'h155, 2'b01, 24);
        t_frame(10'h200, 2'b01, 14);
        t_hold();
        t_capture();
        t_recovery();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule